// File: doc/BRIEF.md
# Nonvolatile Store/Recall Power Sequencer

This controller decides when the contents of a volatile SRAM array are copied into a shadow nonvolatile array (STORE) and when the shadow copy is brought back (RECALL). It watches two digitised supply-monitor flags, a static power-mode strap, an active-low hardware store line and a write-activity pulse from the SRAM bus. It drives a busy flag that blocks SRAM access, per-address copy strobes with a copy address, and a control that isolates the storage capacitor from the supply during an automatic save.

A RECALL request is armed by reset and by every excursion of the supply below the reset level. It runs only once the supply is back above the switch level. A STORE is launched by a supply droop in the two automatic modes, or by a falling edge on the hardware store line in any mode. It is skipped when nothing has been written since the last completed copy. Copies walk the array one address per clock. Busy stays high for a parameterised operation length, which models the restore time or the store time.

Top module: `nv_shadow_seq`

## Requirements
- R1: While reset is held and after it is released, busy, both strobes and disconnect are low. A RECALL request is pending from reset, and no operation starts while the supply-ok flag stays low.
- R2: A high level on supply_low_i latches a RECALL request. The RECALL starts on the first clock on which supply_ok_i is high and supply_low_i is low, however long after the low event that is.
- R3: A RECALL keeps busy high for RECALL_CYCLES cycles. The recall strobe is high for the first DEPTH of those cycles, and copy_addr_o is 0 in the first cycle and rises by one per cycle.
- R4: In mode 2'b00 or 2'b01, a high-to-low change of supply_ok_i with the dirty flag set starts a STORE. Busy is high for STORE_CYCLES cycles, and the store strobe is high for the first DEPTH of them with addresses counting up from 0.
- R5: In mode 2'b10 or 2'b11, a high-to-low change of supply_ok_i starts no operation.
- R6: In every mode, a high-to-low change of hw_store_n_i with the dirty flag set starts a STORE.
- R7: The dirty flag is set by wr_pulse_i while idle and is cleared when a STORE or RECALL completes. A store trigger with the flag clear is ignored.
- R8: A wr_pulse_i while busy does not set the dirty flag.
- R9: A store trigger is ignored while a RECALL request is pending, which includes the whole time before the first RECALL after reset. It is also ignored in a cycle in which supply_low_i is high. In both cases the RECALL wins.
- R10: disconnect_o is high for every busy cycle of an automatic STORE in mode 2'b00, and low at all other times.
- R11: The mode strap is sampled on the first clock after reset is released. Later changes of pmode_i have no effect until the next reset.
- R12: A supply_low_i event during a STORE does not shorten it. The latched RECALL starts after one idle cycle if supply_ok_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| pmode_i | input | 2 | Power-mode strap: 00 capacitor auto-save, 01 system-supply auto-save, 10/11 auto-save inhibited |
| supply_low_i | input | 1 | Capacitor voltage below the reset threshold |
| supply_ok_i | input | 1 | Capacitor voltage above the switch threshold |
| hw_store_n_i | input | 1 | Active-low hardware store request, acted on at its falling edge |
| wr_pulse_i | input | 1 | One-cycle pulse per SRAM write |
| busy_o | output | 1 | STORE or RECALL in progress; SRAM access disabled |
| disconnect_o | output | 1 | Isolate the storage capacitor from the supply |
| store_stb_o | output | 1 | Copy SRAM word at copy_addr_o into the shadow array |
| recall_stb_o | output | 1 | Copy shadow word at copy_addr_o back into SRAM |
| copy_addr_o | output | AW | Address being copied |

## Verification
The RECALL request and a STORE trigger can arise in the same cycle. This happens when the supply crosses both thresholds on one clock edge while the array is dirty. The bench provokes it by lowering supply_ok_i and raising supply_low_i on the same clock with a write outstanding. It then expects busy to stay low, and when the supply recovers it expects a RECALL (recall strobe, not store strobe) to start. A checker property forbids the two internal start events from ever coinciding. A second overlap is a low-supply event that lands inside a running STORE. It is judged by the STORE keeping its full length and the RECALL following after exactly one idle cycle.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nv_op_e;

  localparam logic [1:0] PM_CAP_AUTO = 2'b00;
  localparam logic [1:0] PM_SYS_AUTO = 2'b01;
  localparam logic [1:0] PM_NO_AUTO  = 2'b10;

  // Automatic save allowed in the two modes whose upper bit is clear.
  function automatic logic pm_auto(input logic [1:0] m);
    return ~m[1];
  endfunction

  // Only the capacitor-backed mode isolates the capacitor.
  function automatic logic pm_isolates(input logic [1:0] m);
    return m == PM_CAP_AUTO;
  endfunction

  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic int unsigned op_len(input nv_op_e op,
                                         input int unsigned st_len,
                                         input int unsigned rc_len);
    return (op == OP_STORE) ? st_len : rc_len;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nv_fall_det.sv
module nv_fall_det #(
  parameter int unsigned     N       = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] fall_o
);
  import nv_seq_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL[i];
      else        prev_q <= sig_i[i];
    end
    assign fall_o[i] = fell(prev_q, sig_i[i]);
  end

endmodule

// File: rtl/nv_req_track.sv
module nv_req_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pmode_i,
  input  logic       supply_low_i,
  input  logic       rec_start_i,
  input  logic       op_done_i,
  input  logic       wr_pulse_i,
  input  logic       busy_i,
  output logic       rec_pend_o,
  output logic       dirty_o,
  output logic [1:0] mode_o
);
  import nv_seq_pkg::*;

  logic       rec_pend_q;
  logic       dirty_q;
  logic       strap_taken_q;
  logic [1:0] mode_q;

  // Recall request: armed by reset and by every low-supply cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rec_pend_q <= 1'b1;
    else if (supply_low_i) rec_pend_q <= 1'b1;
    else if (rec_start_i)  rec_pend_q <= 1'b0;
  end

  // Dirty: writes while idle only; any completed copy makes arrays equal.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dirty_q <= 1'b0;
    else if (op_done_i)            dirty_q <= 1'b0;
    else if (wr_pulse_i && !busy_i) dirty_q <= 1'b1;
  end

  // Strap captured once, on the first clock after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_taken_q <= 1'b0;
      mode_q        <= PM_NO_AUTO;
    end else if (!strap_taken_q) begin
      strap_taken_q <= 1'b1;
      mode_q        <= pmode_i;
    end
  end

  assign rec_pend_o = rec_pend_q;
  assign dirty_o    = dirty_q;
  assign mode_o     = mode_q;

endmodule

// File: rtl/nv_copy_engine.sv
module nv_copy_engine #(
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned STORE_CYCLES  = 24,
  parameter int unsigned RECALL_CYCLES = 20,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned MAXD = nv_seq_pkg::max2(STORE_CYCLES, RECALL_CYCLES),
  localparam int unsigned CW   = $clog2(MAXD + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_store_i,
  input  logic                     start_recall_i,
  input  logic                     isolate_i,
  output nv_seq_pkg::nv_op_e       op_o,
  output logic [AW-1:0]            addr_o,
  output logic                     store_stb_o,
  output logic                     recall_stb_o,
  output logic                     isolate_o,
  output logic                     done_o
);
  import nv_seq_pkg::*;

  nv_op_e        op_q;
  logic [CW-1:0] cnt_q;
  logic          iso_q;
  logic [CW-1:0] last_cnt;
  logic          in_copy;

  assign last_cnt = CW'(op_len(op_q, STORE_CYCLES, RECALL_CYCLES) - 1);
  assign done_o   = (op_q != OP_IDLE) && (cnt_q == last_cnt);
  assign in_copy  = cnt_q < CW'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
      iso_q <= 1'b0;
    end else if (op_q == OP_IDLE) begin
      cnt_q <= '0;
      if (start_recall_i) begin
        op_q <= OP_RECALL;
      end else if (start_store_i) begin
        op_q  <= OP_STORE;
        iso_q <= isolate_i;
      end
    end else if (done_o) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
      iso_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign op_o         = op_q;
  assign addr_o       = in_copy ? cnt_q[AW-1:0] : '0;
  assign store_stb_o  = (op_q == OP_STORE)  && in_copy;
  assign recall_stb_o = (op_q == OP_RECALL) && in_copy;
  assign isolate_o    = iso_q;

endmodule

// File: rtl/nv_shadow_seq.sv
module nv_shadow_seq #(
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned STORE_CYCLES  = 24,
  parameter int unsigned RECALL_CYCLES = 20,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pmode_i,
  input  logic          supply_low_i,
  input  logic          supply_ok_i,
  input  logic          hw_store_n_i,
  input  logic          wr_pulse_i,
  output logic          busy_o,
  output logic          disconnect_o,
  output logic          store_stb_o,
  output logic          recall_stb_o,
  output logic [AW-1:0] copy_addr_o
);
  import nv_seq_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [1:0] fall;
  logic       rec_pend;
  logic       dirty;
  logic [1:0] mode_q;
  logic       idle;
  logic       op_done;
  logic       auto_trig;
  logic       hw_trig;
  logic       store_blocked;
  logic       rec_start;
  logic       store_start;
  logic       isolate_req;
  nv_op_e     op;

  nv_fall_det #(
    .N       (2),
    .RST_VAL (2'b10)
  ) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({hw_store_n_i, supply_ok_i}),
    .fall_o (fall)
  );

  nv_req_track u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .pmode_i      (pmode_i),
    .supply_low_i (supply_low_i),
    .rec_start_i  (rec_start),
    .op_done_i    (op_done),
    .wr_pulse_i   (wr_pulse_i),
    .busy_i       (busy_o),
    .rec_pend_o   (rec_pend),
    .dirty_o      (dirty),
    .mode_o       (mode_q)
  );

  assign idle          = (op == OP_IDLE);
  assign auto_trig     = fall[0] & pm_auto(mode_q);
  assign hw_trig       = fall[1];
  assign store_blocked = rec_pend | supply_low_i;
  assign rec_start     = idle & rec_pend & supply_ok_i & ~supply_low_i;
  assign store_start   = idle & (auto_trig | hw_trig) & dirty & ~store_blocked & ~rec_start;
  assign isolate_req   = auto_trig & pm_isolates(mode_q);

  nv_copy_engine #(
    .DEPTH         (DEPTH),
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) u_copy (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_store_i  (store_start),
    .start_recall_i (rec_start),
    .isolate_i      (isolate_req),
    .op_o           (op),
    .addr_o         (copy_addr_o),
    .store_stb_o    (store_stb_o),
    .recall_stb_o   (recall_stb_o),
    .isolate_o      (disconnect_o),
    .done_o         (op_done)
  );

  assign busy_o = ~idle;

endmodule

// File: rtl/nv_seq_chk.sv
module nv_seq_chk #(
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned STORE_CYCLES  = 24,
  parameter int unsigned RECALL_CYCLES = 20,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          disconnect_o,
  input logic          store_stb_o,
  input logic          recall_stb_o,
  input logic [AW-1:0] copy_addr_o,
  input logic          dirty,
  input logic          rec_pend,
  input logic          rec_start,
  input logic          store_start
);

  logic        busy_q;
  logic        kind_store_q;
  int unsigned len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      kind_store_q <= 1'b0;
      len_q        <= 0;
    end else begin
      busy_q <= busy_o;
      len_q  <= busy_o ? len_q + 1 : 0;
      if (busy_o && !busy_q) kind_store_q <= store_stb_o;
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_stb_o && recall_stb_o));

  p_stb_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (store_stb_o || recall_stb_o) |-> busy_o);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((store_stb_o || recall_stb_o) && ($past(store_stb_o) || $past(recall_stb_o)))
      |-> copy_addr_o == $past(copy_addr_o) + 1'b1);

  p_start_addr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !busy_q) |-> (copy_addr_o == '0));

  p_op_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy_o) |-> (len_q == (kind_store_q ? STORE_CYCLES : RECALL_CYCLES)));

  p_store_needs_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !busy_q && store_stb_o) |-> $past(dirty));

  p_clean_after_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy_o) |-> !dirty);

  p_no_store_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !busy_q && store_stb_o) |-> !$past(rec_pend));

  p_starts_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_start && store_start));

  p_disc_in_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect_o |-> (busy_o && !recall_stb_o));

endmodule

bind nv_shadow_seq nv_seq_chk #(
  .DEPTH         (DEPTH),
  .STORE_CYCLES  (STORE_CYCLES),
  .RECALL_CYCLES (RECALL_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .disconnect_o (disconnect_o),
  .store_stb_o  (store_stb_o),
  .recall_stb_o (recall_stb_o),
  .copy_addr_o  (copy_addr_o),
  .dirty        (dirty),
  .rec_pend     (rec_pend),
  .rec_start    (rec_start),
  .store_start  (store_start)
);

// File: tb/tb_nv_shadow_seq.sv
module tb_nv_shadow_seq;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned SC    = 24;
  localparam int unsigned RC    = 20;
  localparam int unsigned AW    = $clog2(DEPTH);

  // {mode[1:0], write, hw_trigger, expect_store, expect_disconnect}
  localparam logic [5:0] VEC [9] = '{
    6'b00_1_0_1_1, 6'b01_1_0_1_0, 6'b10_1_0_0_0, 6'b11_1_0_0_0,
    6'b10_1_1_1_0, 6'b00_0_0_0_0, 6'b00_0_1_0_0, 6'b01_1_1_1_0,
    6'b00_1_1_1_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pmode_i = 2'b00;
  logic supply_low_i = 1'b0, supply_ok_i = 1'b0, hw_store_n_i = 1'b1, wr_pulse_i = 1'b0;
  logic busy_o, disconnect_o, store_stb_o, recall_stb_o;
  logic [AW-1:0] copy_addr_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nv_shadow_seq #(.DEPTH(DEPTH), .STORE_CYCLES(SC), .RECALL_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .pmode_i(pmode_i), .supply_low_i(supply_low_i),
    .supply_ok_i(supply_ok_i), .hw_store_n_i(hw_store_n_i), .wr_pulse_i(wr_pulse_i),
    .busy_o(busy_o), .disconnect_o(disconnect_o), .store_stb_o(store_stb_o),
    .recall_stb_o(recall_stb_o), .copy_addr_o(copy_addr_o));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; pmode_i = m; supply_low_i = 1'b0; supply_ok_i = 1'b0;
    hw_store_n_i = 1'b1; wr_pulse_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic run_op(output int nb, output int ns, output int nbad, output int nd);
    nb = 0; ns = 0; nbad = 0; nd = 0;
    while (busy_o === 1'b1 && nb < 2000) begin
      if (store_stb_o || recall_stb_o) begin
        if (int'(copy_addr_o) != ns) nbad++;
        ns++;
      end
      if (disconnect_o) nd++;
      nb++;
      tick();
    end
  endtask

  task automatic write_once();
    wr_pulse_i = 1'b1; tick(); wr_pulse_i = 1'b0;
  endtask

  task automatic power_up(input bit verbose);
    int nb, ns, nbad, nd;
    supply_ok_i = 1'b1;
    tick();
    if (verbose) begin
      chk(busy_o === 1'b1 && recall_stb_o === 1'b1, "R2 recall starts on supply ok", busy_o, 1);
      chk(copy_addr_o === '0, "R3 recall first address", copy_addr_o, 0);
    end
    run_op(nb, ns, nbad, nd);
    if (verbose) begin
      chk(nb == RC, "R3 recall busy length", nb, RC);
      chk(ns == DEPTH && nbad == 0, "R3 recall strobes and addresses", ns, DEPTH);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nb, ns, nbad, nd;

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) tick();
    chk(busy_o === 1'b0 && store_stb_o === 1'b0 && recall_stb_o === 1'b0 && disconnect_o === 1'b0,
        "R1 outputs quiet in reset", busy_o, 0);
    do_reset(2'b00);
    repeat (4) tick();
    chk(busy_o === 1'b0, "R1 no op while supply below switch", busy_o, 0);

    // R9: store before first recall ignored even when dirty
    write_once();
    hw_store_n_i = 1'b0; tick();
    chk(busy_o === 1'b0, "R9 store before power-up recall", busy_o, 0);
    hw_store_n_i = 1'b1; tick();
    power_up(1'b1);
    // R7: recall cleared the dirty flag
    hw_store_n_i = 1'b0; tick();
    chk(busy_o === 1'b0, "R7 clean after recall ignores store", busy_o, 0);
    hw_store_n_i = 1'b1; tick();

    // R2 and R8: latched recall fires on recovery; write during it ignored
    supply_ok_i = 1'b0; tick();
    supply_low_i = 1'b1; tick();
    supply_low_i = 1'b0;
    repeat (5) tick();
    chk(busy_o === 1'b0, "R2 recall waits for supply ok", busy_o, 0);
    supply_ok_i = 1'b1; tick();
    chk(recall_stb_o === 1'b1, "R2 latched recall starts", recall_stb_o, 1);
    write_once();
    run_op(nb, ns, nbad, nd);
    hw_store_n_i = 1'b0; tick();
    chk(busy_o === 1'b0, "R8 write while busy not recorded", busy_o, 0);
    hw_store_n_i = 1'b1; tick();

    // R12: low event inside a store
    write_once();
    hw_store_n_i = 1'b0; tick();
    chk(store_stb_o === 1'b1, "R6 hw store starts", store_stb_o, 1);
    hw_store_n_i = 1'b1;
    supply_low_i = 1'b1; tick();
    supply_low_i = 1'b0;
    run_op(nb, ns, nbad, nd);
    chk(nb == SC - 1, "R12 store not shortened", nb + 1, SC);
    tick();
    chk(busy_o === 1'b1 && recall_stb_o === 1'b1, "R12 recall follows store", recall_stb_o, 1);
    run_op(nb, ns, nbad, nd);

    // R9: droop and low flag in the same cycle with dirty array
    write_once();
    supply_ok_i = 1'b0; supply_low_i = 1'b1; tick();
    chk(busy_o === 1'b0, "R9 recall wins same-cycle conflict", busy_o, 0);
    supply_low_i = 1'b0; tick();
    supply_ok_i = 1'b1; tick();
    chk(recall_stb_o === 1'b1 && store_stb_o === 1'b0, "R9 recall runs after conflict", recall_stb_o, 1);
    run_op(nb, ns, nbad, nd);

    // R11: strap changes after reset have no effect
    do_reset(2'b00);
    pmode_i = 2'b10;
    power_up(1'b0);
    write_once();
    supply_ok_i = 1'b0; tick();
    chk(busy_o === 1'b1 && disconnect_o === 1'b1, "R11 strap held as auto mode", busy_o, 1);
    run_op(nb, ns, nbad, nd);
    supply_ok_i = 1'b1; tick();
    do_reset(2'b10);
    pmode_i = 2'b00;
    power_up(1'b0);
    write_once();
    supply_ok_i = 1'b0; tick();
    chk(busy_o === 1'b0, "R11 strap held as inhibit mode", busy_o, 0);
    supply_ok_i = 1'b1; tick();

    // Table: R4 R5 R6 R7 R10 across modes and triggers
    for (int i = 0; i < 9; i++) begin
      logic [5:0] v;
      v = VEC[i];
      do_reset(v[5:4]);
      power_up(1'b0);
      if (v[3]) write_once();
      if (v[2]) hw_store_n_i = 1'b0; else supply_ok_i = 1'b0;
      tick();
      chk(busy_o === v[1], $sformatf("R4 R5 R6 R7 vector %0d store start", i), busy_o, v[1]);
      chk(disconnect_o === v[0], $sformatf("R10 vector %0d disconnect", i), disconnect_o, v[0]);
      run_op(nb, ns, nbad, nd);
      if (v[1]) begin
        chk(nb == SC, $sformatf("R4 vector %0d store length", i), nb, SC);
        chk(ns == DEPTH && nbad == 0, $sformatf("R4 vector %0d store addresses", i), ns, DEPTH);
        chk(nd == (v[0] ? SC : 0), $sformatf("R10 vector %0d disconnect span", i), nd, v[0] ? SC : 0);
      end
      supply_ok_i = 1'b1; hw_store_n_i = 1'b1;
      repeat (2) tick();
      chk(busy_o === 1'b0 && disconnect_o === 1'b0, $sformatf("R5 vector %0d idle after", i), busy_o, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule